// File: doc/BRIEF.md
# Codec Board Control and Status Register

This block is the small register slice of a DSP peripheral board that sits behind one strobed region of a processor bus. Two address bits split that region into three targets. The first target is a packed 8-bit control word. It drives a hex LED digit, a 3-bit codec select used while the codecs are set up over I2C, and the release of the codec reset. The second target is the converter data channels, reached by the low address bits. The third target is a configuration PROGRAM pin.

The control word is written in one bus cycle. A read of the same location returns two live status inputs instead of the stored word. An access to the converter channels produces a one-cycle enable with the channel number. The PROGRAM pin is driven by the type of the bus access and never by its data: a write asserts the pin and a read releases it.

The external reset is asserted asynchronously and released synchronously inside the block. Bus accesses should start once that release has passed through, which takes two clock edges.

Top module: `codec_board_regs`

## Requirements
- R1: While reset is active and after it, the LED nibble is 0, the codec select is 0, codec_rst_n is 0 (codecs held in reset), prog_n is 1 and conv_en is 0.
- R2: A strobed write (bus_stb=1, bus_we=1) with addr[20]=0 and addr[4]=1 stores bus_wdata. From the next clock edge, led_nibble shows wdata[3:0].
- R3: After a control write, codec_sel shows wdata[6:4].
- R4: After a control write, codec_rst_n equals wdata[7]. A 1 releases the codecs and a 0 holds them in reset.
- R5: While bus_stb=1, bus_we=0, addr[20]=0 and addr[4]=1, bus_rdata is combinationally {6'b0, lr_stat, irq_stat}. This puts the interrupt status on bit 0, the left/right status on bit 1, and zero on bits 7:2.
- R6: A strobed access with addr[20]=0 and addr[4]=0 raises conv_en for exactly the next cycle, with conv_ch = addr[3:0]. It leaves the control word unchanged.
- R7: A strobed write with addr[20]=1 drives prog_n to 0 from the next edge, whatever the data. It leaves the control word unchanged.
- R8: A strobed read with addr[20]=1 drives prog_n to 1 from the next edge.
- R9: Without bus_stb, no output changes and bus_rdata is 0.
- R10: A read of the control location leaves the control word unchanged. Address bits other than 20 and 4 do not affect which target is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | Strobe for this region, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 21 | Bus address bits 20:0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_stat | input | 1 | Interrupt status, read on bit 0 |
| lr_stat | input | 1 | Left/right status, read on bit 1 |
| led_nibble | output | 4 | Value shown on the hex LED |
| codec_sel | output | 3 | Codec chosen for I2C setup |
| codec_rst_n | output | 1 | Codec reset, low holds the codecs in reset |
| prog_n | output | 1 | Configuration PROGRAM pin, active low |
| conv_en | output | 1 | One-cycle converter channel enable |
| conv_ch | output | 4 | Converter channel number |

## Verification
The assertions are checked on every cycle:
- a decoded control write appears in the stored word one edge later;
- the word holds when no control write is decoded;
- the PROGRAM latch follows set and clear requests;
- the converter enable rises only after a converter access and falls after one cycle.

Only the bench scenarios show the rest:
- the mapping of the stored word onto the LED, select and reset pins;
- the composition of the read data from the status inputs;
- that PROGRAM ignores the write data;
- that stray address bits and strobe-less cycles leave every output alone.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

  typedef struct packed {
    logic       rst_rel;
    logic [2:0] sel;
    logic [3:0] led;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CONV = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_PROG = 2'd3
  } bus_tgt_e;

endpackage

// File: rtl/codec_rst_sync.sv
module codec_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) stage_q <= 2'b00;
    else              stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/codec_bus_decode.sv
module codec_bus_decode
  import codec_regs_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int PROG_BIT = 20,
  parameter int CTRL_BIT = 4,
  parameter int CH_W     = 4
) (
  input  logic              stb,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output bus_tgt_e          tgt,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              prog_set,
  output logic              prog_clr,
  output logic              conv_hit,
  output logic [CH_W-1:0]   conv_ch_nxt
);
  always_comb begin
    tgt = TGT_NONE;
    if (stb) begin
      if (addr[PROG_BIT])      tgt = TGT_PROG;
      else if (addr[CTRL_BIT]) tgt = TGT_CTRL;
      else                     tgt = TGT_CONV;
    end
  end

  assign ctrl_wr     = (tgt == TGT_CTRL) &&  we;
  assign ctrl_rd     = (tgt == TGT_CTRL) && !we;
  assign prog_set    = (tgt == TGT_PROG) &&  we;
  assign prog_clr    = (tgt == TGT_PROG) && !we;
  assign conv_hit    = (tgt == TGT_CONV);
  assign conv_ch_nxt = addr[CH_W-1:0];
endmodule

// File: rtl/codec_ctrl_reg.sv
module codec_ctrl_reg
  import codec_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_word_t        word_q
);
  ctrl_word_t word_d;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d = ctrl_word_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  // R2
  ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (word_q == $past(wdata)));

  // R10
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word_q));
endmodule

// File: rtl/codec_prog_ctl.sv
module codec_prog_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic prog_n
);
  logic act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (set_req)      act_d = 1'b1;
    else if (clr_req) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  assign prog_n = ~act_q;

  // R7
  prog_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> !prog_n);

  // R8
  prog_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> prog_n);
endmodule

// File: rtl/codec_conv_sel.sv
module codec_conv_sel #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [CH_W-1:0] ch_nxt,
  output logic            en,
  output logic [CH_W-1:0] ch
);
  logic            en_d;
  logic [CH_W-1:0] ch_d;

  always_comb begin
    en_d = hit;
    ch_d = ch;
    if (hit) ch_d = ch_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      ch <= '0;
    end else begin
      en <= en_d;
      ch <= ch_d;
    end
  end

  // R6
  conv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (en && ch == $past(ch_nxt)));

  // R6
  conv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !en);
endmodule

// File: rtl/codec_board_regs.sv
module codec_board_regs
  import codec_regs_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 8,
  parameter int PROG_BIT = 20,
  parameter int CTRL_BIT = 4,
  parameter int CH_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_stb,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_stat,
  input  logic              lr_stat,
  output logic [3:0]        led_nibble,
  output logic [2:0]        codec_sel,
  output logic              codec_rst_n,
  output logic              prog_n,
  output logic              conv_en,
  output logic [CH_W-1:0]   conv_ch
);
  localparam int STAT_PAD = DATA_W - 2;

  logic            rst_int_n;
  bus_tgt_e        tgt;
  logic            ctrl_wr, ctrl_rd, prog_set, prog_clr, conv_hit;
  logic [CH_W-1:0] conv_ch_nxt;
  ctrl_word_t      word_q;

  codec_rst_sync u_rst (
    .clk        (clk),
    .rst_async_n(rst_n),
    .rst_sync_n (rst_int_n)
  );

  codec_bus_decode #(
    .ADDR_W  (ADDR_W),
    .PROG_BIT(PROG_BIT),
    .CTRL_BIT(CTRL_BIT),
    .CH_W    (CH_W)
  ) u_dec (
    .stb        (bus_stb),
    .we         (bus_we),
    .addr       (bus_addr),
    .tgt        (tgt),
    .ctrl_wr    (ctrl_wr),
    .ctrl_rd    (ctrl_rd),
    .prog_set   (prog_set),
    .prog_clr   (prog_clr),
    .conv_hit   (conv_hit),
    .conv_ch_nxt(conv_ch_nxt)
  );

  codec_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (ctrl_wr),
    .wdata (bus_wdata),
    .word_q(word_q)
  );

  codec_prog_ctl u_prog (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .set_req(prog_set),
    .clr_req(prog_clr),
    .prog_n (prog_n)
  );

  codec_conv_sel #(.CH_W(CH_W)) u_conv (
    .clk   (clk),
    .rst_n (rst_int_n),
    .hit   (conv_hit),
    .ch_nxt(conv_ch_nxt),
    .en    (conv_en),
    .ch    (conv_ch)
  );

  assign led_nibble  = word_q.led;
  assign codec_sel   = word_q.sel;
  assign codec_rst_n = word_q.rst_rel;
  assign bus_rdata   = ctrl_rd ? {{STAT_PAD{1'b0}}, lr_stat, irq_stat} : '0;

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_stb |=> ($stable(led_nibble) && $stable(codec_sel) &&
                  $stable(codec_rst_n) && $stable(prog_n) && !conv_en));

  // R5
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rdata[DATA_W-1:2] == '0);
endmodule

// File: tb/codec_board_regs_tb.sv
module codec_board_regs_tb_top;
  typedef struct {
    logic [3:0] led;
    logic [2:0] sel;
    logic       rstn;
    logic       progn;
    logic       en;
    logic [3:0] ch;
    string      req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_stb, bus_we, irq_stat, lr_stat;
  logic [20:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [3:0]  led_nibble, conv_ch;
  logic [2:0]  codec_sel;
  logic        codec_rst_n, prog_n, conv_en;

  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];
  logic [7:0] m_ctrl = 8'h00;
  logic       m_progn = 1'b1;

  always #10 clk = ~clk;

  codec_board_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_stat(irq_stat), .lr_stat(lr_stat), .led_nibble(led_nibble),
    .codec_sel(codec_sel), .codec_rst_n(codec_rst_n), .prog_n(prog_n),
    .conv_en(conv_en), .conv_ch(conv_ch)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [20:0] mk_addr(input logic a20, input logic a4,
                                          input logic [3:0] lo, input logic [14:0] mid);
    return {a20, mid, a4, lo};
  endfunction

  // driver: one bus cycle, model update, expected item pushed
  task automatic access(input logic stb, input logic we, input logic [20:0] a,
                        input logic [7:0] d, input string req);
    exp_t it;
    logic [7:0] exp_rd;
    @(negedge clk);
    bus_stb = stb; bus_we = we; bus_addr = a; bus_wdata = d;
    it.en = 1'b0; it.ch = 4'h0; exp_rd = 8'h00;
    if (stb) begin
      if (a[20]) m_progn = we ? 1'b0 : 1'b1;
      else if (a[4]) begin
        if (we) m_ctrl = d;
        else    exp_rd = {6'b0, lr_stat, irq_stat};
      end else begin
        it.en = 1'b1; it.ch = a[3:0];
      end
    end
    it.led = m_ctrl[3:0]; it.sel = m_ctrl[6:4]; it.rstn = m_ctrl[7];
    it.progn = m_progn; it.req = req;
    sb.push_back(it);
    #1;
    chk({req, " rdata"}, bus_rdata, exp_rd);
  endtask

  // monitor: sampled half a phase after the edge that captured the access
  always begin
    @(posedge clk);
    #5;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      chk({it.req, " led"},   led_nibble,  it.led);
      chk({it.req, " sel"},   codec_sel,   it.sel);
      chk({it.req, " rstn"},  codec_rst_n, it.rstn);
      chk({it.req, " prog_n"},prog_n,      it.progn);
      chk({it.req, " conv_en"}, conv_en,   it.en);
      if (it.en) chk({it.req, " conv_ch"}, conv_ch, it.ch);
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_stb = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq_stat = 1'b0; lr_stat = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 led", led_nibble, 0);
    chk("R1 rstn", codec_rst_n, 0);
    chk("R1 prog_n", prog_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 after release
    chk("R1 sel", codec_sel, 0);
    chk("R1 conv_en", conv_en, 0);

    // R2 R3 R4
    access(1, 1, mk_addr(0, 1, 4'h0, 15'h0), 8'hA5, "R2 R3 R4 wr A5");
    access(1, 1, mk_addr(0, 1, 4'h0, 15'h0), 8'h3C, "R2 R3 R4 wr 3C");
    // R10 stray address bits still decode to control
    access(1, 1, mk_addr(0, 1, 4'h9, 15'h0401), 8'hE7, "R10 stray bits wr");
    // R5 status reads, R10 no change
    irq_stat = 1'b1; lr_stat = 1'b0;
    access(1, 0, mk_addr(0, 1, 4'h0, 15'h0), 8'hFF, "R5 R10 rd irq");
    irq_stat = 1'b0; lr_stat = 1'b1;
    access(1, 0, mk_addr(0, 1, 4'h0, 15'h0), 8'h00, "R5 rd lr");
    irq_stat = 1'b1; lr_stat = 1'b1;
    access(1, 0, mk_addr(0, 1, 4'h0, 15'h0), 8'h00, "R5 rd both");
    // R6 converter channels
    access(1, 0, mk_addr(0, 0, 4'h7, 15'h0), 8'h00, "R6 conv rd 7");
    access(0, 0, mk_addr(0, 0, 4'h0, 15'h0), 8'h00, "R6 pulse end");
    access(1, 1, mk_addr(0, 0, 4'hF, 15'h0), 8'hFF, "R6 conv wr F");
    access(1, 1, mk_addr(0, 0, 4'h2, 15'h0), 8'h00, "R6 conv wr 2");
    // R7 R8 PROGRAM pin, data ignored
    access(1, 1, mk_addr(1, 0, 4'h0, 15'h0), 8'h00, "R7 prog set d00");
    access(1, 0, mk_addr(1, 1, 4'h0, 15'h0), 8'h00, "R8 prog clr");
    access(1, 1, mk_addr(1, 1, 4'h5, 15'h0), 8'hFF, "R7 prog set dFF");
    access(0, 1, mk_addr(1, 0, 4'h0, 15'h0), 8'h00, "R9 idle hold prog");
    access(1, 0, mk_addr(1, 0, 4'h0, 15'h0), 8'h00, "R8 prog clr 2");
    // R9 no strobe: writes ignored, rdata 0
    access(0, 1, mk_addr(0, 1, 4'h0, 15'h0), 8'h00, "R9 idle wr ctrl");
    access(0, 0, mk_addr(0, 1, 4'h0, 15'h0), 8'h00, "R9 idle rd ctrl");
    access(0, 0, mk_addr(0, 0, 4'h3, 15'h0), 8'h00, "R9 idle conv");
    // R4 hold codecs in reset again
    access(1, 1, mk_addr(0, 1, 4'h0, 15'h0), 8'h7F, "R4 wr 7F");
    access(0, 0, mk_addr(0, 0, 4'h0, 15'h0), 8'h00, "R9 drain");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule